// File: doc/BRIEF.md
# Timer clock source selector

This block produces the count-enable strobe that advances a timer/counter. A 3-bit select input picks the source: none (timer frozen), every system clock cycle, one of four divided rates from a shared free-running prescaler, or the falling or rising edges of an external clock pin. The strobe is one system clock cycle wide and lives entirely in the system clock domain.

The external pin is sampled through a synchronizer before edge detection, so a slow asynchronous signal can step the count. It is treated as a plain input, and software that drives the pin itself can use it to step the timer. A clear input restarts the prescaler, so that a divided rate can be started from a known phase. The select input is captured in a register that resets to the stop code.

Top module: `tmr_clk_sel`

## Requirements
- R1: While reset is held and in the first cycle after it, `cntEn` is 0; the captured select value resets to 000 (stop) and the prescaler to zero.
- R2: With select code 000, `cntEn` is never asserted, whatever the pin and the prescaler do.
- R3: With select code 001, `cntEn` is high in every cycle.
- R4: Codes 010, 011, 100 and 101 select divide-by 8, 64, 256 and 1024. Counting clock edges from 1 after reset release or after the edge that sampled a clear, `cntEn` is high for one cycle right after edge k when k is a multiple of N.
- R5: With code 110, each falling edge of `extPin` gives exactly one `cntEn` pulse, high right after the third clock edge that follows the pin change.
- R6: `presClr` high at a clock edge zeroes the prescaler and suppresses any divided pulse due at that edge; the next divided pulse follows N edges later.
- R7: With code 111, each rising edge of `extPin` gives exactly one `cntEn` pulse with the same three-edge latency as R5.
- R8: A new select value present at one clock edge governs `cntEn` from the second clock edge onward; the prescaler phase is not disturbed by a change of select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clkSel | input | 3 | Clock source select code |
| presClr | input | 1 | Synchronous prescaler clear |
| extPin | input | 1 | Asynchronous external clock pin |
| cntEn | output | 1 | One-cycle count-enable strobe |

## Verification
Each result has a fixed delay: a select change shows two edges later, a divided pulse appears right after edge N of the prescaler period, and a pin edge appears three clock edges after the pin moves. The bench model works out, at every clock edge, what `cntEn` must be after that edge. It does so from the inputs it sampled at earlier edges, and it queues that value. A monitor compares the queued value with the output at the following falling edge. Directed probes count falling edges after a clear or a select change to confirm the R6 and R8 delays.

// File: rtl/tmr_clk_pkg.sv
package tmr_clk_pkg;
  localparam int PRE_W       = 10;
  localparam int NUM_TAPS    = 4;
  localparam int SYNC_STAGES = 2;

  // log2 of each divide ratio, lowest first
  function automatic int tapLog(input int idx);
    case (idx)
      0: tapLog = 3;
      1: tapLog = 6;
      2: tapLog = 8;
      default: tapLog = 10;
    endcase
  endfunction

  typedef enum logic [2:0] {
    SRC_STOP     = 3'b000,
    SRC_DIV1     = 3'b001,
    SRC_DIV8     = 3'b010,
    SRC_DIV64    = 3'b011,
    SRC_DIV256   = 3'b100,
    SRC_DIV1024  = 3'b101,
    SRC_EXT_FALL = 3'b110,
    SRC_EXT_RISE = 3'b111
  } clk_src_e;

  typedef struct packed {
    logic [NUM_TAPS-1:0] tap;
    logic                extRise;
    logic                extFall;
  } tick_t;
endpackage

// File: rtl/tmr_clk_dp.sv
module tmr_clk_dp
  import tmr_clk_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  presClr,
  input  logic  extPin,
  output tick_t tick
);
  localparam int CHAIN_W = SYNC_STAGES + 1;

  logic [PRE_W-1:0]   presCnt;
  logic [CHAIN_W-1:0] syncQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) presCnt <= '0;
    else if (presClr) presCnt <= '0;
    else presCnt <= presCnt + 1'b1;
  end

  // each tap fires when its low-order bits are about to wrap
  for (genvar gi = 0; gi < NUM_TAPS; gi++) begin : g_tap
    localparam int LOGW = tapLog(gi);
    assign tick.tap[gi] = (&presCnt[LOGW-1:0]) && !presClr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) syncQ <= '0;
    else syncQ <= {syncQ[CHAIN_W-2:0], extPin};
  end

  assign tick.extRise =  syncQ[SYNC_STAGES-1] && !syncQ[SYNC_STAGES];
  assign tick.extFall = !syncQ[SYNC_STAGES-1] &&  syncQ[SYNC_STAGES];

  // R6: a clear leaves the prescaler at zero
  p_clear_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    presClr |=> (presCnt == '0));

  // R5 / R7: one edge kind at a time
  p_edge_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tick.extRise, tick.extFall}));

  // R7: a detected rise lasts a single cycle
  p_rise_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tick.extRise |=> !tick.extRise);

  // R4: slower taps are nested inside faster ones
  for (genvar gj = 1; gj < NUM_TAPS; gj++) begin : g_nest
    p_tap_nested_r4: assert property (@(posedge clk) disable iff (!rst_n)
      tick.tap[gj] |-> tick.tap[gj-1]);
  end
endmodule

// File: rtl/tmr_clk_ctl.sv
module tmr_clk_ctl
  import tmr_clk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] clkSel,
  input  tick_t      tick,
  output logic       cntEn
);
  clk_src_e selReg;
  logic     enNext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) selReg <= SRC_STOP;
    else selReg <= clk_src_e'(clkSel);
  end

  always_comb begin
    case (selReg)
      SRC_DIV1:     enNext = 1'b1;
      SRC_DIV8:     enNext = tick.tap[0];
      SRC_DIV64:    enNext = tick.tap[1];
      SRC_DIV256:   enNext = tick.tap[2];
      SRC_DIV1024:  enNext = tick.tap[3];
      SRC_EXT_FALL: enNext = tick.extFall;
      SRC_EXT_RISE: enNext = tick.extRise;
      default:      enNext = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cntEn <= 1'b0;
    else cntEn <= enNext;
  end

  // R2: stop code keeps the strobe low
  p_stop_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (selReg == SRC_STOP) |=> !cntEn);

  // R3: undivided code gives a strobe every cycle
  p_full_rate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (selReg == SRC_DIV1) |=> cntEn);

  // R5: falling-edge mode pulses only on a detected fall
  p_fall_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((selReg == SRC_EXT_FALL) && !tick.extFall) |=> !cntEn);
endmodule

// File: rtl/tmr_clk_sel.sv
module tmr_clk_sel
  import tmr_clk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] clkSel,
  input  logic       presClr,
  input  logic       extPin,
  output logic       cntEn
);
  tick_t tick;

  tmr_clk_dp u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .presClr (presClr),
    .extPin  (extPin),
    .tick    (tick)
  );

  tmr_clk_ctl u_ctl (
    .clk    (clk),
    .rst_n  (rst_n),
    .clkSel (clkSel),
    .tick   (tick),
    .cntEn  (cntEn)
  );
endmodule

// File: tb/tmr_clk_sel_bench.sv
`timescale 1ns/1ps
module tmr_clk_sel_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] clkSel = 3'b000;
  logic       presClr = 1'b0;
  logic       extPin = 1'b0;
  logic       cntEn;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct { bit exp; string tag; } item_t;
  item_t sbq[$];

  tmr_clk_sel u_tmr_clk_sel (
    .clk(clk), .rst_n(rst_n), .clkSel(clkSel),
    .presClr(presClr), .extPin(extPin), .cntEn(cntEn)
  );

  always #2.5 clk = ~clk;

  // reference model: state of the previous edges
  int  mAge = 0;
  int  mSel = 0;
  bit  pinH1 = 0, pinH2 = 0, pinH3 = 0;
  bit  lastClr = 0;

  function automatic int divOf(input int code);
    case (code)
      2: divOf = 8;
      3: divOf = 64;
      4: divOf = 256;
      default: divOf = 1024;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mAge = 0; mSel = 0; pinH1 = 0; pinH2 = 0; pinH3 = 0;
      sbq.delete();
    end else begin
      item_t it;
      it.exp = 0;
      case (mSel)
        0: begin it.exp = 0; it.tag = "R2"; end
        1: begin it.exp = 1; it.tag = "R3"; end
        2, 3, 4, 5: begin
          it.exp = ((mAge % divOf(mSel)) == divOf(mSel) - 1) && !presClr;
          it.tag = presClr ? "R6" : "R4";
        end
        6: begin it.exp = !pinH2 && pinH3; it.tag = "R5"; end
        default: begin it.exp = pinH2 && !pinH3; it.tag = "R7"; end
      endcase
      sbq.push_back(it);
      mAge  = presClr ? 0 : (mAge + 1) % 1024;
      mSel  = int'(clkSel);
      pinH3 = pinH2; pinH2 = pinH1; pinH1 = extPin;
    end
  end

  // monitor: compare away from the active edge
  always @(negedge clk) begin
    if (rst_n && sbq.size() > 0) begin
      item_t it;
      it = sbq.pop_front();
      checks++;
      if (cntEn !== it.exp) begin
        errors++;
        $display("FAIL %s: cntEn=%0b expected %0b at %0t", it.tag, cntEn, it.exp, $time);
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pinWave(input int hold, input int toggles);
    for (int i = 0; i < toggles; i++) begin
      extPin = ~extPin;
      idle(hold);
    end
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      finishRun();
    end
  end

  initial begin
    int firstHi;
    idle(4);
    check("R1", int'(cntEn), 0);           // in reset
    rst_n = 1'b1;
    idle(1);
    check("R1", int'(cntEn), 0);           // first cycle after reset

    // R2: stopped while the pin toggles
    pinWave(3, 12);
    // R3 and R8: switch from stop to undivided
    clkSel = 3'd1;
    firstHi = 0;
    for (int j = 1; j <= 6; j++) begin
      @(negedge clk);
      if (cntEn && firstHi == 0) firstHi = j;
    end
    check("R8", firstHi, 2);
    idle(20);

    // R4: each divided rate
    clkSel = 3'd2; idle(60);
    // R6: clear during divide-by-8, next pulse a full period later
    presClr = 1'b1;
    firstHi = 0;
    for (int j = 1; j <= 20; j++) begin
      @(negedge clk);
      if (j == 1) presClr = 1'b0;
      if (cntEn && firstHi == 0) firstHi = j;
    end
    check("R6", firstHi, 9);
    clkSel = 3'd3; idle(200);
    clkSel = 3'd4; idle(600);
    presClr = 1'b1; idle(1); presClr = 1'b0;
    clkSel = 3'd5; idle(2300);

    // R5: falling edges with various hold times
    clkSel = 3'd6; idle(3);
    pinWave(4, 10);
    pinWave(1, 8);
    pinWave(2, 9);
    // R7: rising edges
    clkSel = 3'd7; idle(3);
    pinWave(5, 10);
    pinWave(1, 8);
    pinWave(3, 7);
    // switch back to stop; model covers the tail
    clkSel = 3'd0; idle(10);
    done = 1'b1;
    finishRun();
  end
endmodule